// File: doc/BRIEF.md
# Multiphase Ramp Start Sequencer

This block is instantiated once per phase of a paralleled converter group. It decides when its phase begins and ends its soft-start ramp so that every phase of the group ramps on the same clock cycle. After enable, each phase counts its own programmed turn-on delay in milliseconds. A member phase then freezes in a wait state. The reference phase is configured with a longer delay. When that delay expires it drives a one-cycle pulse onto the shared ramp flag line. Every phase watches that line, the reference included, and fires its ramp-up strobe one cycle after the pulse, so all phases start together.

Turn-off works the same way: each phase counts its turn-off delay, the reference pulses the flag, and all phases fire a ramp-down strobe on the same cycle. The block also reports a configuration error when a reference's delays are not at least a fixed margin (10 ms by default) longer than the largest member delays. It enables the minimum pulse width, one switching period divided by 128, while the phase is switching. It keeps the sync-clock output alive either always or for a timeout (500 ms by default) after enable falls.

Top module: `ramp_sync_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, flag_out, ramp_up_stb, ramp_dn_stb, min_duty_en, min_pw, cfg_err and sync_oe are all 0.
- R2: A member (is_ref = 0) that has finished its turn-on delay does not ramp on its own. It holds until a flag_in pulse, and ramp_up_stb is high in the single cycle after the cycle in which flag_in was high.
- R3: Let enable first be sampled high at clock edge E. A reference (is_ref = 1) then drives flag_out high for exactly the one cycle after edge E + on_dly_ms·CLK_PER_MS + 1. With flag_out looped back to flag_in, its ramp_up_stb fires in the same cycle as every member's.
- R4: A flag_in pulse while the phase is not waiting for it (idle, still counting a delay, or running) causes no strobe and no state change.
- R5: If en falls while the phase counts its turn-on delay or waits for the flag, the phase returns to idle without issuing ramp_up_stb or flag_out.
- R6: When en falls while running, the phase counts off_dly_ms. The reference then pulses flag_out, and every phase fires ramp_dn_stb one cycle after the flag_in pulse, with the same timing rule as R3.
- R7: cfg_err is 1 exactly when is_ref = 1 and either on_dly_ms < peer_on_dly_ms + MARGIN_MS or off_dly_ms < peer_off_dly_ms + MARGIN_MS. It is always 0 for a member and follows its inputs one cycle later.
- R8: min_duty_en is high from the ramp_up_stb cycle until the cycle before ramp_dn_stb, provided min_duty_cfg = 1. While it is high, min_pw equals floor(sw_period / DUTY_DIV); otherwise min_pw is 0.
- R9: With sync_always_on = 0, sync_oe is high while en is high. Let en first be sampled low at edge F. sync_oe stays high through edge F + SYNC_TO_MS·CLK_PER_MS − 1 and goes low at edge F + SYNC_TO_MS·CLK_PER_MS.
- R10: With sync_always_on = 1, sync_oe is high on every cycle after reset, regardless of en.
- R11: flag_out, ramp_up_stb and ramp_dn_stb are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Phase enable (on/off request) |
| is_ref | input | 1 | 1 = reference phase, 0 = member phase |
| on_dly_ms | input | DLY_W | Turn-on delay in milliseconds |
| off_dly_ms | input | DLY_W | Turn-off delay in milliseconds |
| peer_on_dly_ms | input | DLY_W | Largest member turn-on delay (checked by a reference) |
| peer_off_dly_ms | input | DLY_W | Largest member turn-off delay (checked by a reference) |
| min_duty_cfg | input | 1 | Minimum-duty feature enabled |
| sw_period | input | PER_W | Switching period in clock cycles |
| sync_always_on | input | 1 | Sync output never times out |
| flag_in | input | 1 | Shared ramp flag line as observed |
| flag_out | output | 1 | Ramp flag pulse driven by a reference |
| ramp_up_stb | output | 1 | Start soft-start ramp-up |
| ramp_dn_stb | output | 1 | Start ramp-down |
| min_duty_en | output | 1 | Minimum pulse width enforced |
| min_pw | output | PER_W | Minimum pulse width in clock cycles |
| sync_oe | output | 1 | Sync clock output enable |
| cfg_err | output | 1 | Reference delay margin violated |

## Verification
The embedded properties check on every cycle that the strobes and the flag are exclusive single-cycle pulses. They also check that a strobe only follows a flag_in pulse, that the flag comes only from a reference, that a dropped enable in the turn-on states leads straight to idle, and that a member never raises cfg_err. The sync output is checked to be held while en or the always-on setting is present. Only the bench scenarios can show the exact millisecond-scaled cycle at which the reference flags and every phase strobes together. They also show that stray flags are ignored in each non-waiting state, that the sync output lasts exactly the timeout after en falls, and the cfg_err margin boundaries.

// File: rtl/rss_pkg.sv
// Shared types for the ramp start sequencer.
// Assumes: one state encoding is used by the sequencer FSM and the top.
package rss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ON_DLY   = 3'd1,
        ST_ON_WAIT  = 3'd2,
        ST_RUN      = 3'd3,
        ST_OFF_DLY  = 3'd4,
        ST_OFF_WAIT = 3'd5
    } seq_state_t;
endpackage

// File: rtl/rss_ms_timer.sv
// Millisecond counter: a prescaler divides clk by CLK_PER_MS and a
// saturating counter counts elapsed milliseconds since the last clear.
// Assumes: clear restarts both prescaler and counter on the same edge.
module rss_ms_timer #(
    parameter int CLK_PER_MS = 250000,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] ms_cnt
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;

    // Prescale clk to a millisecond tick and count ticks with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q  <= '0;
            ms_cnt <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (ms_cnt != '1) begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R9
    ms_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ms_cnt >= $past(ms_cnt)));
endmodule

// File: rtl/rss_seq_fsm.sv
// Phase sequencer: counts turn-on/turn-off delays, lets a reference emit
// the shared ramp flag, and fires ramp strobes one cycle after flag_in.
// Assumes: flag_in carries the OR of all phases' flag_out, so a reference
// sees its own pulse and ramps in the same cycle as the members.
module rss_seq_fsm
    import rss_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             is_ref,
    input  logic [DLY_W-1:0] on_dly_ms,
    input  logic [DLY_W-1:0] off_dly_ms,
    input  logic             flag_in,
    input  logic [CNT_W-1:0] ms_cnt,
    output seq_state_t       state,
    output logic             timer_clr,
    output logic             flag_out,
    output logic             up_stb,
    output logic             dn_stb
);
    seq_state_t state_nxt;
    logic       flag_set;
    logic       up_set;
    logic       dn_set;
    logic       on_done;
    logic       off_done;

    assign on_done  = (ms_cnt >= CNT_W'(on_dly_ms));
    assign off_done = (ms_cnt >= CNT_W'(off_dly_ms));

    // Next-state and event decode; an enable drop before running wins.
    always_comb begin
        state_nxt = state;
        timer_clr = 1'b0;
        flag_set  = 1'b0;
        up_set    = 1'b0;
        dn_set    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (en) begin
                    state_nxt = ST_ON_DLY;
                    timer_clr = 1'b1;
                end
            end
            ST_ON_DLY: begin
                if (!en) begin
                    state_nxt = ST_IDLE;
                end else if (on_done) begin
                    state_nxt = ST_ON_WAIT;
                    flag_set  = is_ref;
                end
            end
            ST_ON_WAIT: begin
                if (!en) begin
                    state_nxt = ST_IDLE;
                end else if (flag_in) begin
                    state_nxt = ST_RUN;
                    up_set    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_nxt = ST_OFF_DLY;
                    timer_clr = 1'b1;
                end
            end
            ST_OFF_DLY: begin
                if (off_done) begin
                    state_nxt = ST_OFF_WAIT;
                    flag_set  = is_ref;
                end
            end
            ST_OFF_WAIT: begin
                if (flag_in) begin
                    state_nxt = ST_IDLE;
                    dn_set    = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Register state and the single-cycle flag and strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            flag_out <= 1'b0;
            up_stb   <= 1'b0;
            dn_stb   <= 1'b0;
        end else begin
            state    <= state_nxt;
            flag_out <= flag_set;
            up_stb   <= up_set;
            dn_stb   <= dn_set;
        end
    end

    // R2
    up_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_stb |-> $past(flag_in));
    // R6
    dn_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb |-> $past(flag_in));
    // R3
    flag_from_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_out |-> $past(is_ref));
    // R5
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && (state == ST_ON_DLY || state == ST_ON_WAIT))
        |=> (!up_stb && !flag_out && state == ST_IDLE));
    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_out, up_stb, dn_stb}));
    // R11
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_out |=> !flag_out);
    // R11
    up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_stb |=> !up_stb);
endmodule

// File: rtl/rss_sync_keeper.sv
// Sync output enable: held while enabled, kept for TIMEOUT_MS after enable
// falls, or held permanently when always-on is selected.
// Assumes: the millisecond timer is cleared for as long as en is high.
module rss_sync_keeper #(
    parameter int CLK_PER_MS = 250000,
    parameter int TIMEOUT_MS = 500,
    parameter int CNT_W      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic always_on,
    output logic sync_oe
);
    logic [CNT_W-1:0] ms_cnt;
    logic             armed_q;
    logic             expired;

    rss_ms_timer #(
        .CLK_PER_MS(CLK_PER_MS),
        .CNT_W     (CNT_W)
    ) u_hold_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (en),
        .ms_cnt(ms_cnt)
    );

    assign expired = (ms_cnt >= CNT_W'(TIMEOUT_MS));

    // Arm on enable, disarm at timeout, register the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sync_oe <= 1'b0;
        end else begin
            armed_q <= en | (armed_q & ~expired);
            sync_oe <= always_on | en | (armed_q & ~expired);
        end
    end

    // R10
    always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(always_on)) |-> sync_oe);
    // R9
    oe_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> sync_oe);
endmodule

// File: rtl/rss_cfg_check.sv
// Delay margin check for a reference phase: both its delays must exceed
// the largest member delays by at least MARGIN_MS.
// Assumes: peer delays are the maxima over the group's members.
module rss_cfg_check #(
    parameter int DLY_W     = 8,
    parameter int MARGIN_MS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_ref,
    input  logic [DLY_W-1:0] on_dly_ms,
    input  logic [DLY_W-1:0] off_dly_ms,
    input  logic [DLY_W-1:0] peer_on_dly_ms,
    input  logic [DLY_W-1:0] peer_off_dly_ms,
    output logic             cfg_err
);
    localparam int SUM_W = DLY_W + $clog2(MARGIN_MS + 1) + 1;

    logic [SUM_W-1:0] on_need;
    logic [SUM_W-1:0] off_need;
    logic             short_on;
    logic             short_off;

    assign on_need   = SUM_W'(peer_on_dly_ms) + SUM_W'(MARGIN_MS);
    assign off_need  = SUM_W'(peer_off_dly_ms) + SUM_W'(MARGIN_MS);
    assign short_on  = (SUM_W'(on_dly_ms) < on_need);
    assign short_off = (SUM_W'(off_dly_ms) < off_need);

    // Register the error so it follows the configuration one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= is_ref & (short_on | short_off);
        end
    end

    // R7
    member_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_ref) |-> !cfg_err);
endmodule

// File: rtl/ramp_sync_seq.sv
// Top of the per-phase ramp start sequencer: ties the delay timer, the
// sequencer FSM, the sync keeper, the margin check and minimum duty output.
// Assumes: flag_in is the wired-OR of every phase's flag_out in the group.
module ramp_sync_seq
    import rss_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    parameter int DLY_W      = 8,
    parameter int PER_W      = 12,
    parameter int MARGIN_MS  = 10,
    parameter int SYNC_TO_MS = 500,
    parameter int DUTY_DIV   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             is_ref,
    input  logic [DLY_W-1:0] on_dly_ms,
    input  logic [DLY_W-1:0] off_dly_ms,
    input  logic [DLY_W-1:0] peer_on_dly_ms,
    input  logic [DLY_W-1:0] peer_off_dly_ms,
    input  logic             min_duty_cfg,
    input  logic [PER_W-1:0] sw_period,
    input  logic             sync_always_on,
    input  logic             flag_in,
    output logic             flag_out,
    output logic             ramp_up_stb,
    output logic             ramp_dn_stb,
    output logic             min_duty_en,
    output logic [PER_W-1:0] min_pw,
    output logic             sync_oe,
    output logic             cfg_err
);
    localparam int TO_W      = $clog2(SYNC_TO_MS + 1);
    localparam int CNT_W     = ((DLY_W > TO_W) ? DLY_W : TO_W) + 1;
    localparam int MIN_SHIFT = $clog2(DUTY_DIV);

    seq_state_t       state;
    logic             timer_clr;
    logic [CNT_W-1:0] dly_ms;
    logic             switching;

    rss_ms_timer #(
        .CLK_PER_MS(CLK_PER_MS),
        .CNT_W     (CNT_W)
    ) u_dly_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clr),
        .ms_cnt(dly_ms)
    );

    rss_seq_fsm #(
        .DLY_W(DLY_W),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .is_ref    (is_ref),
        .on_dly_ms (on_dly_ms),
        .off_dly_ms(off_dly_ms),
        .flag_in   (flag_in),
        .ms_cnt    (dly_ms),
        .state     (state),
        .timer_clr (timer_clr),
        .flag_out  (flag_out),
        .up_stb    (ramp_up_stb),
        .dn_stb    (ramp_dn_stb)
    );

    rss_sync_keeper #(
        .CLK_PER_MS(CLK_PER_MS),
        .TIMEOUT_MS(SYNC_TO_MS),
        .CNT_W     (CNT_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .always_on(sync_always_on),
        .sync_oe  (sync_oe)
    );

    rss_cfg_check #(
        .DLY_W    (DLY_W),
        .MARGIN_MS(MARGIN_MS)
    ) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .is_ref         (is_ref),
        .on_dly_ms      (on_dly_ms),
        .off_dly_ms     (off_dly_ms),
        .peer_on_dly_ms (peer_on_dly_ms),
        .peer_off_dly_ms(peer_off_dly_ms),
        .cfg_err        (cfg_err)
    );

    // Minimum duty is enforced while the phase is switching.
    assign switching   = (state == ST_RUN) || (state == ST_OFF_DLY) ||
                         (state == ST_OFF_WAIT);
    assign min_duty_en = min_duty_cfg & switching;
    assign min_pw      = min_duty_en ? (sw_period >> MIN_SHIFT) : '0;

    // R8
    min_duty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(min_duty_en) |-> ramp_up_stb);
endmodule

// File: tb/ramp_sync_seq_tb.sv
`timescale 1ns/1ps
// Bench: one reference and one member share a flag line. A driver task
// queues expected flag/strobe events with their cycle; a monitor pops and
// compares them as the outputs pulse. Direct checks cover the rest.
module ramp_sync_seq_tb;
    localparam int P   = 4;
    localparam int S   = 500;
    localparam int DW  = 8;
    localparam int PW  = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic en_m, en_r, flag_tb, mdc_m;
    logic [DW-1:0] ron, roff;
    logic [PW-1:0] per;
    logic flag_m, flag_r, up_m, up_r, dn_m, dn_r, md_m, md_r;
    logic [PW-1:0] pw_m, pw_r;
    logic oe_m, oe_r, err_m, err_r;
    logic flag_bus;
    assign flag_bus = flag_m | flag_r | flag_tb;

    ramp_sync_seq #(.CLK_PER_MS(P), .DLY_W(DW), .PER_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en_m), .is_ref(1'b0),
        .on_dly_ms(8'd3), .off_dly_ms(8'd2),
        .peer_on_dly_ms(8'd50), .peer_off_dly_ms(8'd50),
        .min_duty_cfg(mdc_m), .sw_period(per), .sync_always_on(1'b0),
        .flag_in(flag_bus), .flag_out(flag_m), .ramp_up_stb(up_m),
        .ramp_dn_stb(dn_m), .min_duty_en(md_m), .min_pw(pw_m),
        .sync_oe(oe_m), .cfg_err(err_m));

    ramp_sync_seq #(.CLK_PER_MS(P), .DLY_W(DW), .PER_W(PW)) u_ref (
        .clk(clk), .rst_n(rst_n), .en(en_r), .is_ref(1'b1),
        .on_dly_ms(ron), .off_dly_ms(roff),
        .peer_on_dly_ms(8'd3), .peer_off_dly_ms(8'd2),
        .min_duty_cfg(1'b1), .sw_period(per), .sync_always_on(1'b1),
        .flag_in(flag_bus), .flag_out(flag_r), .ramp_up_stb(up_r),
        .ramp_dn_stb(dn_r), .min_duty_en(md_r), .min_pw(pw_r),
        .sync_oe(oe_r), .cfg_err(err_r));

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int c; int k; } ev_t;
    ev_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int k);
        if (k == 2) return "R2";
        if (k == 4 || k == 5) return "R6";
        return "R3";
    endfunction

    task automatic push(input int c, input int k);
        ev_t e;
        e.c = c; e.k = k;
        expq.push_back(e);
    endtask

    // Monitor: compare each observed pulse against the queue head.
    task automatic obs(input int k);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R4", "unexpected pulse kind", k, 0);
        end else begin
            e = expq.pop_front();
            chk(e.k == k, req_of(e.k), "pulse kind", k, e.k);
            chk(e.c == cyc, req_of(e.k), "pulse cycle", cyc, e.c);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (flag_r) obs(1);
            if (up_m)   obs(2);
            if (up_r)   obs(3);
            if (dn_m)   obs(4);
            if (dn_r)   obs(5);
            chk(!(up_r && dn_r) && !(flag_r && up_r), "R11", "pulse overlap",
                int'(up_r & dn_r), 0);
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: raise enables and queue the expected up events.
    task automatic run_up(input bit with_mem, output int c0);
        c0 = cyc;
        if (with_mem) en_m = 1'b1;
        en_r = 1'b1;
        push(c0 + 2 + int'(ron) * P, 1);
        if (with_mem) push(c0 + 3 + int'(ron) * P, 2);
        push(c0 + 3 + int'(ron) * P, 3);
    endtask

    task automatic run_down(input bit with_mem, output int c1);
        c1 = cyc;
        if (with_mem) en_m = 1'b0;
        en_r = 1'b0;
        push(c1 + 2 + int'(roff) * P, 1);
        if (with_mem) push(c1 + 3 + int'(roff) * P, 4);
        push(c1 + 3 + int'(roff) * P, 5);
    endtask

    task automatic pulse_flag();
        flag_tb = 1'b1;
        @(negedge clk);
        flag_tb = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c0, c1;
        rst_n = 1'b0; en_m = 1'b0; en_r = 1'b0; flag_tb = 1'b0; mdc_m = 1'b1;
        ron = 8'd13; roff = 8'd12; per = 12'd1000;
        repeat (3) @(negedge clk);
        // R1: outputs held low in reset
        chk({flag_r, up_r, dn_r, md_r, oe_r, err_r} == 6'b0, "R1", "ref outputs in reset",
            int'({flag_r, up_r, dn_r, md_r, oe_r, err_r}), 0);
        chk({flag_m, up_m, dn_m, md_m, oe_m, err_m} == 6'b0 && pw_m == 0, "R1",
            "member outputs in reset", int'({flag_m, up_m, dn_m, md_m, oe_m, err_m}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(oe_m == 1'b0, "R9", "member sync before enable", int'(oe_m), 0);
        @(negedge clk);
        chk(oe_r == 1'b1, "R10", "always-on sync", int'(oe_r), 1);
        chk(err_r == 1'b0, "R7", "ref margin exactly met", int'(err_r), 0);

        // Scenario A: synchronised start, stray flags ignored
        run_up(1'b1, c0);
        wait_until(c0 + 4);
        pulse_flag();                     // R4: both still counting delay
        wait_until(c0 + 10);
        chk(md_m == 1'b0, "R8", "min duty before ramp", int'(md_m), 0);
        wait_until(c0 + 4 + 13 * P);
        chk(!up_m && !up_r, "R11", "strobe single cycle", int'(up_m | up_r), 0);
        chk(md_m && md_r, "R8", "min duty while running", int'(md_m & md_r), 1);
        chk(pw_m == 12'd7, "R8", "min pulse width", int'(pw_m), 7);
        pulse_flag();                     // R4: running phases ignore it
        wait_until(c0 + 30 + 13 * P);
        chk(md_m == 1'b1, "R4", "member still running after stray flag", int'(md_m), 1);
        chk(expq.size() == 0, "R2", "all start events seen", expq.size(), 0);

        // Scenario B: synchronised stop and sync timeout
        run_down(1'b1, c1);
        wait_until(c1 + 3 + 12 * P);
        chk(md_m == 1'b0 && pw_m == 0, "R8", "min duty off after ramp down", int'(md_m), 0);
        wait_until(c1 + S * P - 1);
        chk(oe_m == 1'b1, "R9", "sync held before timeout", int'(oe_m), 1);
        wait_until(c1 + S * P);
        chk(oe_m == 1'b1, "R9", "sync last held cycle", int'(oe_m), 1);
        wait_until(c1 + S * P + 1);
        chk(oe_m == 1'b0, "R9", "sync off at timeout", int'(oe_m), 0);
        chk(oe_r == 1'b1, "R10", "always-on sync after timeout", int'(oe_r), 1);
        chk(expq.size() == 0, "R6", "all stop events seen", expq.size(), 0);

        // Scenario C: enable dropped during delay
        c0 = cyc;
        en_m = 1'b1; en_r = 1'b1;
        wait_until(c0 + 5);
        en_m = 1'b0; en_r = 1'b0;
        wait_until(c0 + 20 * P);
        chk(!md_m && !md_r, "R5", "idle after abort in delay", int'(md_m | md_r), 0);

        // Scenario D: member aborts while waiting; its flag is ignored
        run_up(1'b0, c0);
        en_m = 1'b1;
        wait_until(c0 + 2 + 3 * P + 4);
        en_m = 1'b0;
        wait_until(c0 + 6 + 13 * P);
        chk(md_m == 1'b0, "R5", "member idle after abort in wait", int'(md_m), 0);
        chk(md_r == 1'b1, "R3", "reference running alone", int'(md_r), 1);
        run_down(1'b0, c1);
        wait_until(c1 + 8 + 12 * P);
        chk(expq.size() == 0, "R5", "no member events after abort", expq.size(), 0);

        // Scenario E: reference margin boundaries
        ron = 8'd12;
        repeat (2) @(negedge clk);
        chk(err_r == 1'b1, "R7", "on margin short by 1", int'(err_r), 1);
        chk(err_m == 1'b0, "R7", "member never flags", int'(err_m), 0);
        ron = 8'd13; roff = 8'd11;
        repeat (2) @(negedge clk);
        chk(err_r == 1'b1, "R7", "off margin short by 1", int'(err_r), 1);
        roff = 8'd12;
        repeat (2) @(negedge clk);
        chk(err_r == 1'b0, "R7", "margins met", int'(err_r), 0);

        // Scenario F: minimum duty disabled on the member
        mdc_m = 1'b0;
        run_up(1'b1, c0);
        wait_until(c0 + 6 + 13 * P);
        chk(md_m == 1'b0 && pw_m == 0, "R8", "min duty disabled", int'(pw_m), 0);
        chk(md_r == 1'b1 && pw_r == 12'd7, "R8", "ref min pulse width", int'(pw_r), 7);
        run_down(1'b1, c1);
        wait_until(c1 + 8 + 12 * P);
        chk(expq.size() == 0, "R6", "events after min duty run", expq.size(), 0);

        summary();
        $finish;
    end
endmodule